// File: doc/BRIEF.md
# Store Effective Address Generator

This block forms the 64-bit effective address for the integer store family and decides whether the base register must be rewritten. Each request carries a form code, the base register number and value, an index register value and a 16-bit displacement field. The form code picks one of three offset sources and says whether the form writes back. The offset is a sign-extended 16-bit immediate, the index register value, or a 14-bit field scaled by four and sign-extended. The register file and the memory port sit outside the block. The block takes in their operands and hands out a memory request, a write-back request and an invalid-form flag.

The base operand depends on the write-back bit. A form without write-back treats register number 0 as a literal zero. A form with write-back always uses the register value. For such a form, register number 0 is an illegal encoding: it raises the invalid flag and blocks both requests. The address path is a single 64-bit adder. It is followed by an optional register stage, chosen by parameter and enabled by default.

Top module: `st_ea_gen`

## Requirements
- R1: For a form without write-back (form_sel[0]=0), the base operand is 0 when base_idx is 0 and base_val otherwise.
- R2: Immediate kind (form_sel[2:1]=00): ea = base + the 16-bit disp sign-extended to 64 bits.
- R3: Indexed kind (form_sel[2:1]=01): ea = base + index_val.
- R4: Scaled kind (form_sel[2:1]=10): ea = base + sign-extension to 64 bits of {disp[13:0], 2'b00}. disp[15:14] has no effect on ea.
- R5: A write-back form (form_sel[0]=1) uses base_val as the base. When legal, it raises wb_en_o with wb_idx_o = base_idx, and the value to write is ea_o. A form without write-back never raises wb_en_o.
- R6: A write-back form with base_idx = 0 raises invalid_o.
- R7: While invalid_o is high, req_o and wb_en_o are low.
- R8: The addition wraps modulo 2^64 and no carry is reported.
- R9: Form kind code 11 is reserved and raises invalid_o.
- R10: With REG_OUT=1, the results of a request sampled at a rising edge appear on the outputs after that edge. While rst_n is low, or after a cycle with in_valid low, req_o, wb_en_o and invalid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| form_sel | input | 3 | [2:1] offset kind (00 imm, 01 indexed, 10 scaled, 11 reserved), [0] write-back |
| base_idx | input | 5 | Base register number |
| base_val | input | 64 | Base register content |
| index_val | input | 64 | Index register content |
| disp | input | 16 | Displacement field; the scaled kind uses [13:0] |
| ea_o | output | 64 | Effective address, also the write-back value |
| req_o | output | 1 | Memory request valid |
| wb_en_o | output | 1 | Base register write-back request |
| wb_idx_o | output | 5 | Register number to write back |
| invalid_o | output | 1 | Invalid instruction form |

## Verification
The assertions check three properties on every cycle. An invalid form never lets a memory or write-back request out. A write-back never targets register 0 and always comes with a memory request. The adder output keeps the base's low two bits for the scaled kind and equals the sign-extended displacement for an immediate form with zero base. Only the bench scenarios can show the exact address values, which cover negative displacements, the ignored upper displacement bits and 64-bit wrap. They also show the write-back register number, the reserved kind code, the one-cycle latency and the reset state.

// File: rtl/st_ea_pkg.sv
package st_ea_pkg;
  typedef enum logic [1:0] {
    KIND_IMM = 2'b00,
    KIND_IDX = 2'b01,
    KIND_SCL = 2'b10,
    KIND_RSV = 2'b11
  } ea_kind_e;

  typedef struct packed {
    ea_kind_e kind;
    logic     upd;
  } form_t;
endpackage

// File: rtl/st_ea_operand.sv
module st_ea_operand
  import st_ea_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5,
  parameter int DISP_W = 16,
  parameter int DS_W   = 14
) (
  input  form_t             form,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   base_op,
  output logic [XLEN-1:0]   off_op,
  output logic              bad_form
);
  localparam int IMM_EXT = XLEN - DISP_W;
  localparam int SCL_EXT = XLEN - DS_W - 2;

  logic            base_zero;
  logic [XLEN-1:0] imm_off;
  logic [XLEN-1:0] scl_off;

  assign base_zero = (base_idx == '0);
  assign imm_off   = {{IMM_EXT{disp[DISP_W-1]}}, disp};
  assign scl_off   = {{SCL_EXT{disp[DS_W-1]}}, disp[DS_W-1:0], 2'b00};

  always_comb begin
    base_op = (!form.upd && base_zero) ? '0 : base_val;
    case (form.kind)
      KIND_IMM: off_op = imm_off;
      KIND_IDX: off_op = index_val;
      KIND_SCL: off_op = scl_off;
      default:  off_op = '0;
    endcase
    bad_form = (form.upd && base_zero) || (form.kind == KIND_RSV);
  end
endmodule

// File: rtl/st_ea_adder.sv
module st_ea_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum
);
  assign sum = a + b;
endmodule

// File: rtl/st_ea_outreg.sv
module st_ea_outreg #(
  parameter int XLEN    = 64,
  parameter int RIDX_W  = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XLEN-1:0]   ea_d,
  input  logic              req_d,
  input  logic              wb_d,
  input  logic [RIDX_W-1:0] idx_d,
  input  logic              inv_d,
  output logic [XLEN-1:0]   ea_q,
  output logic              req_q,
  output logic              wb_q,
  output logic [RIDX_W-1:0] idx_q,
  output logic              inv_q
);
  generate
    if (REG_OUT) begin : g_reg
      logic [XLEN-1:0]   ea_nxt;
      logic [RIDX_W-1:0] idx_nxt;

      always_comb begin
        ea_nxt  = load ? ea_d  : ea_q;
        idx_nxt = load ? idx_d : idx_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ea_q  <= '0;
          idx_q <= '0;
          req_q <= 1'b0;
          wb_q  <= 1'b0;
          inv_q <= 1'b0;
        end else begin
          ea_q  <= ea_nxt;
          idx_q <= idx_nxt;
          req_q <= req_d;
          wb_q  <= wb_d;
          inv_q <= inv_d;
        end
      end
    end else begin : g_comb
      logic unused_load;
      assign unused_load = load;
      assign ea_q  = ea_d;
      assign idx_q = idx_d;
      assign req_q = req_d;
      assign wb_q  = wb_d;
      assign inv_q = inv_d;
    end
  endgenerate

  // R7: an invalid form lets no request through
  assert_inv_blocks_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> (!req_q && !wb_q));
  // R6: write-back never targets register zero
  assert_wb_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_q |-> (idx_q != '0));
  // R5: a write-back rides with a memory request
  assert_wb_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_q |-> req_q);
endmodule

// File: rtl/st_ea_gen.sv
module st_ea_gen
  import st_ea_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int RIDX_W  = 5,
  parameter int DISP_W  = 16,
  parameter int DS_W    = 14,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        form_sel,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   ea_o,
  output logic              req_o,
  output logic              wb_en_o,
  output logic [RIDX_W-1:0] wb_idx_o,
  output logic              invalid_o
);
  localparam int IMM_EXT = XLEN - DISP_W;

  form_t           form;
  logic [XLEN-1:0] base_op;
  logic [XLEN-1:0] off_op;
  logic [XLEN-1:0] ea_c;
  logic            bad_form;
  logic            req_c;
  logic            wb_c;
  logic            inv_c;

  assign form = form_t'(form_sel);

  st_ea_operand #(
    .XLEN(XLEN), .RIDX_W(RIDX_W), .DISP_W(DISP_W), .DS_W(DS_W)
  ) u_operand (
    .form      (form),
    .base_idx  (base_idx),
    .base_val  (base_val),
    .index_val (index_val),
    .disp      (disp),
    .base_op   (base_op),
    .off_op    (off_op),
    .bad_form  (bad_form)
  );

  st_ea_adder #(.XLEN(XLEN)) u_adder (
    .a   (base_op),
    .b   (off_op),
    .sum (ea_c)
  );

  always_comb begin
    inv_c = in_valid && bad_form;
    req_c = in_valid && !bad_form;
    wb_c  = req_c && form.upd;
  end

  st_ea_outreg #(
    .XLEN(XLEN), .RIDX_W(RIDX_W), .REG_OUT(REG_OUT)
  ) u_outreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .ea_d  (ea_c),
    .req_d (req_c),
    .wb_d  (wb_c),
    .idx_d (base_idx),
    .inv_d (inv_c),
    .ea_q  (ea_o),
    .req_q (req_o),
    .wb_q  (wb_en_o),
    .idx_q (wb_idx_o),
    .inv_q (invalid_o)
  );

  // R1: zero base field without write-back means a literal zero base
  assert_zero_base_imm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !form.upd && base_idx == '0 && form.kind == KIND_IMM)
      |-> (ea_c == {{IMM_EXT{disp[DISP_W-1]}}, disp}));
  // R4: scaled offset leaves the base's low two bits untouched
  assert_scaled_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form.kind == KIND_SCL) |-> (ea_c[1:0] == base_op[1:0]));
endmodule

// File: tb/st_ea_gen_bench.sv
module st_ea_gen_bench;
  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  form;
    logic [4:0]  idx;
    logic [63:0] bval;
    logic [63:0] xval;
    logic [15:0] disp;
    logic [63:0] ea;
    logic        chk_ea;
    logic        req;
    logic        wb;
    logic        inv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R2 positive immediate
    '{4'd2, 3'b000, 5'd3, 64'h1000, 64'h0, 16'h0010, 64'h1010, 1'b1, 1'b1, 1'b0, 1'b0},
    // R2 negative immediate
    '{4'd2, 3'b000, 5'd3, 64'h1000, 64'h0, 16'hFFF0, 64'h0FF0, 1'b1, 1'b1, 1'b0, 1'b0},
    // R1 zero base, immediate
    '{4'd1, 3'b000, 5'd0, 64'hDEAD, 64'h0, 16'h0020, 64'h0020, 1'b1, 1'b1, 1'b0, 1'b0},
    // R3 indexed
    '{4'd3, 3'b010, 5'd4, 64'h0100, 64'h23, 16'h0000, 64'h0123, 1'b1, 1'b1, 1'b0, 1'b0},
    // R1 zero base, indexed
    '{4'd1, 3'b010, 5'd0, 64'h5555, 64'h40, 16'h0000, 64'h0040, 1'b1, 1'b1, 1'b0, 1'b0},
    // R4 scaled positive
    '{4'd4, 3'b100, 5'd2, 64'h2000, 64'h0, 16'h0003, 64'h200C, 1'b1, 1'b1, 1'b0, 1'b0},
    // R4 scaled negative
    '{4'd4, 3'b100, 5'd2, 64'h2000, 64'h0, 16'h3FFF, 64'h1FFC, 1'b1, 1'b1, 1'b0, 1'b0},
    // R4 upper disp bits ignored
    '{4'd4, 3'b100, 5'd2, 64'h2000, 64'h0, 16'hC001, 64'h2004, 1'b1, 1'b1, 1'b0, 1'b0},
    // R5 immediate with write-back
    '{4'd5, 3'b001, 5'd7, 64'h8000, 64'h0, 16'h0008, 64'h8008, 1'b1, 1'b1, 1'b1, 1'b0},
    // R5 indexed with write-back
    '{4'd5, 3'b011, 5'd9, 64'h0010, 64'h20, 16'h0000, 64'h0030, 1'b1, 1'b1, 1'b1, 1'b0},
    // R5 scaled with write-back, register 31
    '{4'd5, 3'b101, 5'd31, 64'h0040, 64'h0, 16'h0002, 64'h0048, 1'b1, 1'b1, 1'b1, 1'b0},
    // R6 write-back immediate with register 0, base value still used
    '{4'd6, 3'b001, 5'd0, 64'h0100, 64'h0, 16'h0004, 64'h0104, 1'b1, 1'b0, 1'b0, 1'b1},
    // R6 write-back indexed with register 0
    '{4'd6, 3'b011, 5'd0, 64'h0100, 64'h8, 16'h0000, 64'h0108, 1'b0, 1'b0, 1'b0, 1'b1},
    // R9 reserved kind
    '{4'd9, 3'b110, 5'd5, 64'h0100, 64'h8, 16'h0000, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1},
    // R8 wrap through indexed
    '{4'd8, 3'b010, 5'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'h0000, 64'h0010, 1'b1, 1'b1, 1'b0, 1'b0},
    // R8 wrap below zero
    '{4'd8, 3'b000, 5'd1, 64'h0004, 64'h0, 16'hFFF8, 64'hFFFF_FFFF_FFFF_FFFC, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  form_sel;
  logic [4:0]  base_idx;
  logic [63:0] base_val;
  logic [63:0] index_val;
  logic [15:0] disp;
  logic [63:0] ea_o;
  logic        req_o;
  logic        wb_en_o;
  logic [4:0]  wb_idx_o;
  logic        invalid_o;

  int checks;
  int errors;

  st_ea_gen u_st_ea_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form_sel(form_sel),
    .base_idx(base_idx), .base_val(base_val), .index_val(index_val),
    .disp(disp), .ea_o(ea_o), .req_o(req_o), .wb_en_o(wb_en_o),
    .wb_idx_o(wb_idx_o), .invalid_o(invalid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input int rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_idle(input int rq);
    chk(rq, "req", {63'd0, req_o}, 64'd0);
    chk(rq, "wb_en", {63'd0, wb_en_o}, 64'd0);
    chk(rq, "invalid", {63'd0, invalid_o}, 64'd0);
  endtask

  initial begin
    fork
      begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL R10 watchdog expired actual 1 expected 0");
      end
      begin
        checks = 0;
        errors = 0;
        rst_n = 1'b0;
        in_valid = 1'b0;
        form_sel = '0;
        base_idx = '0;
        base_val = '0;
        index_val = '0;
        disp = '0;
        repeat (3) @(negedge clk);
        chk_idle(10); // R10 reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
          in_valid  = 1'b1;
          form_sel  = VECS[i].form;
          base_idx  = VECS[i].idx;
          base_val  = VECS[i].bval;
          index_val = VECS[i].xval;
          disp      = VECS[i].disp;
          @(negedge clk);
          if (VECS[i].chk_ea)
            chk(int'(VECS[i].rq), "ea", ea_o, VECS[i].ea);
          chk(int'(VECS[i].rq), "req", {63'd0, req_o}, {63'd0, VECS[i].req});
          chk(int'(VECS[i].rq), "wb_en", {63'd0, wb_en_o}, {63'd0, VECS[i].wb});
          chk(int'(VECS[i].rq), "invalid", {63'd0, invalid_o}, {63'd0, VECS[i].inv});
          if (VECS[i].wb)
            chk(int'(VECS[i].rq), "wb_idx", {59'd0, wb_idx_o}, {59'd0, VECS[i].idx});
        end

        // R10: latency of one edge, outputs unchanged before it
        in_valid = 1'b1; form_sel = 3'b001; base_idx = 5'd12;
        base_val = 64'h700; disp = 16'h0010;
        @(posedge clk); #1;
        chk(10, "ea after edge", ea_o, 64'h710);
        chk(10, "wb_en after edge", {63'd0, wb_en_o}, 64'd1);
        @(negedge clk);
        form_sel = 3'b000; base_val = 64'h900;
        #1;
        chk(10, "ea before edge", ea_o, 64'h710);
        @(negedge clk);
        chk(5, "non-update wb_en", {63'd0, wb_en_o}, 64'd0);

        // R10: idle cycle clears the request flags
        in_valid = 1'b0; form_sel = 3'b001; base_idx = 5'd0;
        @(negedge clk);
        chk_idle(10);

        // R10: asynchronous reset clears flags mid-run
        in_valid = 1'b1; form_sel = 3'b011; base_idx = 5'd6;
        @(negedge clk);
        chk(5, "wb_en before reset", {63'd0, wb_en_o}, 64'd1);
        #1 rst_n = 1'b0;
        #1;
        chk_idle(10);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule